// File: doc/BRIEF.md
# Load-Address Stride Prefetcher

This block watches the stream of load instructions that a core retires or executes and learns, per instruction, whether its effective addresses march through memory by a fixed step. A direct-mapped history table is indexed by the low bits of the load's program counter. Each entry keeps the rest of the program counter as a tag, the address the instruction touched last, the step it took last and a three-level confidence state (init, transient, steady). Once an instruction has repeated the same nonzero step, every further access produces a prefetch request for the address one step ahead. Steps may be positive, negative (loops walking downward) or zero; a zero step is learned but never prefetched.

Loads arrive on a valid/ready input stream and prefetch requests leave on a valid/ready output stream held in a single output register. A load is accepted only when that register is empty or is being drained in the same cycle. While a prefetch waits on `pf_ready`, `ld_ready` stays low, so no history update and no prefetch is ever lost. The prefetch produced by a load appears on the output one cycle after the load handshake.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset `pf_valid` is 0, `ld_ready` is 1, and every table entry is empty, so the first load of any instruction produces no prefetch.
- R2: A load whose table slot is empty or holds a different tag takes over the slot with its address, a step of 0 and the init state, and produces no prefetch.
- R3: The second load of an instruction in init stores the step (new address minus previous address, modulo 2^ADDR_W), moves to transient, and produces no prefetch.
- R4: A load whose step equals the stored step of a transient or steady entry leaves the entry steady and, when the step is nonzero, requests the prefetch address = load address + step.
- R5: Negative steps are handled in two's complement with address wrap-around, so a downward walk prefetches the next lower address.
- R6: An entry that settles on a step of 0 reaches steady but never produces a prefetch.
- R7: A step mismatch in the steady state stores the new step, drops to transient and produces no prefetch; the following matching load returns to steady and prefetches.
- R8: A step mismatch in the transient state stores the new step and stays transient with no prefetch.
- R9: The slot is chosen by `ld_pc[IDX_W-1:0]` and the tag is `ld_pc[PC_W-1:IDX_W]`; two instructions that share a slot but differ in tag evict each other and never prefetch while alternating.
- R10: `ld_ready` is 1 exactly when `pf_valid` is 0 or `pf_ready` is 1; while `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` and `pf_addr` hold their values.
- R11: The prefetch caused by a load accepted at a clock edge is presented on `pf_valid`/`pf_addr` right after that edge.
- R12: The previous-address field is replaced by the load address on every accepted load, whatever the state and whether or not the steps matched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load observation is offered |
| ld_ready | output | 1 | The block accepts the offered load this cycle |
| ld_pc | input | PC_W | Program counter of the load |
| ld_addr | input | ADDR_W | Effective address of the load |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The consumer takes the prefetch request this cycle |
| pf_addr | output | ADDR_W | Address to prefetch |

## Verification
The interesting coincidence is a table update that yields a fresh prefetch in the very cycle the previous prefetch is drained: the output register must swap its contents without a bubble and without dropping either request. The bench drives `pf_ready` from a pseudo-random pattern during the stream sweeps, so drains, stalls and back-to-back steady loads collide in many orders. A cycle-exact reference model predicts, for every sampled cycle, the value of `ld_ready`, whether a prefetch is present and which address it carries, and any difference is reported against the requirement it breaks.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;

  // Confidence level of one history entry.
  typedef enum logic [1:0] {
    CONF_INIT   = 2'd0,
    CONF_TRANS  = 2'd1,
    CONF_STEADY = 2'd2
  } conf_e;

endpackage

// File: rtl/spf_table.sv
module spf_table
  import stride_pf_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 28,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_prev,
  output logic [ADDR_W-1:0] rd_stride,
  output conf_e             rd_state,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_prev,
  input  logic [ADDR_W-1:0] wr_stride,
  input  conf_e             wr_state
);

  localparam int DEPTH = 1 << IDX_W;

  logic              ent_v      [DEPTH];
  logic [TAG_W-1:0]  ent_tag    [DEPTH];
  logic [ADDR_W-1:0] ent_prev   [DEPTH];
  logic [ADDR_W-1:0] ent_stride [DEPTH];
  conf_e             ent_state  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_v[g]      <= 1'b0;
        ent_tag[g]    <= '0;
        ent_prev[g]   <= '0;
        ent_stride[g] <= '0;
        ent_state[g]  <= CONF_INIT;
      end else if (sel) begin
        ent_v[g]      <= 1'b1;
        ent_tag[g]    <= wr_tag;
        ent_prev[g]   <= wr_prev;
        ent_stride[g] <= wr_stride;
        ent_state[g]  <= wr_state;
      end
    end
  end

  assign rd_valid  = ent_v[rd_idx];
  assign rd_tag    = ent_tag[rd_idx];
  assign rd_prev   = ent_prev[rd_idx];
  assign rd_stride = ent_stride[rd_idx];
  assign rd_state  = ent_state[rd_idx];

  // R12: a written slot holds the written previous address afterwards.
  a_r12_prev_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_prev[$past(wr_idx)] == $past(wr_prev));

  // R9: a written slot is occupied afterwards with the written tag.
  a_r9_slot_taken: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_v[$past(wr_idx)] && ent_tag[$past(wr_idx)] == $past(wr_tag));

endmodule

// File: rtl/spf_next.sv
module spf_next
  import stride_pf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              hit,
  input  conf_e             cur_state,
  input  logic [ADDR_W-1:0] cur_prev,
  input  logic [ADDR_W-1:0] cur_stride,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] nxt_prev,
  output logic [ADDR_W-1:0] nxt_stride,
  output conf_e             nxt_state,
  output logic              pf_req,
  output logic [ADDR_W-1:0] pf_addr
);

  logic [ADDR_W-1:0] step;
  logic              same_step;

  assign step      = addr - cur_prev;
  assign same_step = (step == cur_stride);
  assign nxt_prev  = addr;

  always_comb begin
    nxt_stride = '0;
    nxt_state  = CONF_INIT;
    if (hit) begin
      nxt_stride = step;
      unique case (cur_state)
        CONF_TRANS, CONF_STEADY: nxt_state = same_step ? CONF_STEADY : CONF_TRANS;
        default:                 nxt_state = CONF_TRANS;
      endcase
    end
  end

  assign pf_req  = (nxt_state == CONF_STEADY) && (nxt_stride != '0);
  assign pf_addr = addr + nxt_stride;

endmodule

// File: rtl/spf_out_reg.sv
module spf_out_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_pf,
  input  logic [ADDR_W-1:0] up_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);

  logic take;

  assign up_ready = !pf_valid || pf_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else if (take) begin
      pf_valid <= up_pf;
      if (up_pf) pf_addr <= up_addr;
    end else if (pf_ready) begin
      pf_valid <= 1'b0;
    end
  end

  // R10: a stalled request keeps its contents.
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

  // R11: a request only appears after an accepted load.
  a_r11_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> $past(take));

endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher
  import stride_pf_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [PC_W-1:0]   ld_pc,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);

  localparam int TAG_W = PC_W - IDX_W;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_prev;
  logic [ADDR_W-1:0] rd_stride;
  conf_e             rd_state;
  logic              hit;
  logic              ld_fire;
  logic [ADDR_W-1:0] nxt_prev;
  logic [ADDR_W-1:0] nxt_stride;
  conf_e             nxt_state;
  logic              nxt_pf;
  logic [ADDR_W-1:0] nxt_pf_addr;

  assign idx     = ld_pc[IDX_W-1:0];
  assign tag     = ld_pc[PC_W-1:IDX_W];
  assign hit     = rd_valid && (rd_tag == tag);
  assign ld_fire = ld_valid && ld_ready;

  spf_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (idx),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .rd_prev   (rd_prev),
    .rd_stride (rd_stride),
    .rd_state  (rd_state),
    .wr_en     (ld_fire),
    .wr_idx    (idx),
    .wr_tag    (tag),
    .wr_prev   (nxt_prev),
    .wr_stride (nxt_stride),
    .wr_state  (nxt_state)
  );

  spf_next #(.ADDR_W(ADDR_W)) u_next (
    .hit        (hit),
    .cur_state  (rd_state),
    .cur_prev   (rd_prev),
    .cur_stride (rd_stride),
    .addr       (ld_addr),
    .nxt_prev   (nxt_prev),
    .nxt_stride (nxt_stride),
    .nxt_state  (nxt_state),
    .pf_req     (nxt_pf),
    .pf_addr    (nxt_pf_addr)
  );

  spf_out_reg #(.ADDR_W(ADDR_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (ld_valid),
    .up_ready (ld_ready),
    .up_pf    (nxt_pf),
    .up_addr  (nxt_pf_addr),
    .pf_valid (pf_valid),
    .pf_ready (pf_ready),
    .pf_addr  (pf_addr)
  );

  // R2: a load that misses the table never prefetches.
  a_r2_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire && !hit |=> !pf_valid);

  // R4: a confirmed nonzero step in a trained entry yields address plus step.
  a_r4_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire && hit && (rd_state != CONF_INIT) && (ld_addr - rd_prev == rd_stride)
      && (rd_stride != '0)
    |=> pf_valid && pf_addr == $past(ld_addr + rd_stride));

  // R3: the second access of an instruction never prefetches.
  a_r3_second_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire && hit && (rd_state == CONF_INIT) |=> !pf_valid);

  // R6: a zero step is never requested.
  a_r6_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire && (ld_addr == rd_prev) |=> !pf_valid);

endmodule

// File: tb/stride_prefetcher_bench.sv
`timescale 1ns/1ps
module stride_prefetcher_bench;

  localparam int PC_W   = 32;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 4;
  localparam int DEPTH  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ld_valid = 1'b0;
  logic              ld_ready;
  logic [PC_W-1:0]   ld_pc = '0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic              pf_valid;
  logic              pf_ready = 1'b1;
  logic [ADDR_W-1:0] pf_addr;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  stride_prefetcher #(.PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_stride_prefetcher (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_pc(ld_pc), .ld_addr(ld_addr), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  // Reference table: 0 init, 1 transient, 2 steady.
  logic              m_v    [DEPTH];
  logic [PC_W-1:0]   m_pc   [DEPTH];
  logic [ADDR_W-1:0] m_prev [DEPTH];
  logic [ADDR_W-1:0] m_str  [DEPTH];
  int                m_st   [DEPTH];

  logic              exp_v = 1'b0;
  logic [ADDR_W-1:0] exp_a = '0;
  string             exp_tag = "R1";
  logic [15:0]       lfsr = 16'hACE1;
  bit                rand_ready = 1'b0;

  task automatic check(input bit ok, input string req, input logic [ADDR_W-1:0] act,
                       input logic [ADDR_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] a);
    int i;
    logic [ADDR_W-1:0] d;
    i = int'(pc[IDX_W-1:0]);
    d = a - m_prev[i];
    exp_v = 1'b0;
    if (!m_v[i] || m_pc[i][PC_W-1:IDX_W] != pc[PC_W-1:IDX_W]) begin
      m_v[i] = 1'b1; m_pc[i] = pc; m_str[i] = '0; m_st[i] = 0;
      exp_tag = m_v[i] ? "R2 R9" : "R2";
    end else if (m_st[i] == 0) begin
      m_str[i] = d; m_st[i] = 1; exp_tag = "R3";
    end else if (d == m_str[i]) begin
      m_st[i] = 2;
      if (d != '0) begin
        exp_v = 1'b1; exp_a = a + d;
        exp_tag = d[ADDR_W-1] ? "R5 R12" : "R4 R12";
      end else exp_tag = "R6";
    end else begin
      exp_tag = (m_st[i] == 2) ? "R7" : "R8";
      m_str[i] = d; m_st[i] = 1;
    end
    m_prev[i] = a;
  endtask

  // One cycle: drive at the falling edge, compare, then advance the model.
  task automatic cycle(input bit v, input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] a,
                       output bit taken);
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pf_ready = rand_ready ? lfsr[0] : 1'b1;
    ld_valid = v; ld_pc = pc; ld_addr = a;
    #0.5;
    check(pf_valid == exp_v, {exp_tag, " R11 valid"}, ADDR_W'(pf_valid), ADDR_W'(exp_v));
    if (pf_valid && exp_v) check(pf_addr == exp_a, {exp_tag, " addr"}, pf_addr, exp_a);
    check(ld_ready == (!exp_v || pf_ready), "R10 ready", ADDR_W'(ld_ready),
          ADDR_W'(!exp_v || pf_ready));
    taken = v && (!exp_v || pf_ready);
    if (exp_v && pf_ready) exp_v = 1'b0;
    if (taken) model_step(pc, a);
  endtask

  task automatic send(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] a);
    bit t;
    t = 1'b0;
    while (!t) cycle(1'b1, pc, a, t);
  endtask

  task automatic idle(input int n);
    bit t;
    for (int k = 0; k < n; k++) cycle(1'b0, '0, '0, t);
  endtask

  int strides [8] = '{4, -4, 8, -64, 0, 1, -1, 400};

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 1'b0; m_pc[i] = '0; m_prev[i] = '0; m_str[i] = '0; m_st[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    check(pf_valid == 1'b0, "R1 pf_valid", ADDR_W'(pf_valid), '0);
    check(ld_ready == 1'b1, "R1 ld_ready", ADDR_W'(ld_ready), 32'd1);
    rst_n = 1'b1;

    // Stream sweep: four interleaved instructions per pass, step changes midway.
    for (int p = 0; p < 16; p++) begin
      rand_ready = (p % 2 == 1);
      for (int n = 0; n < 9; n++) begin
        for (int s = 0; s < 4; s++) begin
          int s1, s2;
          logic [ADDR_W-1:0] a;
          logic [PC_W-1:0] pc;
          s1 = strides[(p + s) % 8];
          s2 = strides[(p + s + 3) % 8];
          a  = 32'h0010_0000 * (s + 1) + 32'(p * 4096);
          a  = (n < 4) ? a + 32'(n * s1) : a + 32'(4 * s1 + (n - 4) * s2);
          pc = 32'h0000_4000 + 32'((p % 3) * 64) + 32'(s * 4 + (p % 4));
          send(pc, a);
        end
      end
      idle(2);
    end

    // R9: two instructions sharing a slot keep evicting each other.
    rand_ready = 1'b0;
    for (int n = 0; n < 8; n++) begin
      send(32'h0000_8005, 32'h2000 + 32'(n * 8));
      send(32'h0000_8015, 32'h9000 + 32'(n * 8));
    end

    // R8: ever-growing steps stay transient, then a repeated step locks (R4).
    begin
      logic [ADDR_W-1:0] a;
      a = 32'h0004_0000;
      for (int n = 1; n <= 6; n++) begin a = a + 32'(n * 4); send(32'h0000_0107, a); end
      for (int n = 0; n < 4; n++) begin a = a + 32'd24; send(32'h0000_0107, a); end
    end

    // R5: downward walk across address zero wraps around.
    rand_ready = 1'b1;
    for (int n = 0; n < 8; n++) send(32'h0000_0209, 32'h0000_0010 - 32'(n * 8));

    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=%0d expected<100000", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

endmodule